// File: doc/BRIEF.md
# Dual-Order Burst Address Sequencer

This block produces the address that a synchronous memory uses during a burst. The caller supplies a full start address once. On each later cycle the block steps through up to four locations without a new address. Only the two lowest address bits move. The upper bits keep the value they had when the address was loaded.

The order of the moving bits depends on a mode input. In linear order the low bits count up by one and wrap at four. In interleaved order the low bits are the loaded low bits XORed with a beat count. A low level on the advance/load input loads a new address. A high level advances the burst. An active-low clock enable freezes the block while it is high.

After the fourth beat the sequence starts again from the loaded address. The block takes no chip-select or write-enable input, so an advance happens whatever state the surrounding access logic is in. The block also reports a beat index, which counts the beats since the last load.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low, and in the cycle after it is released, addr_o and beat_o are both zero.
- R2: When clk_en_ni is low and adv_i is low at a rising edge, addr_o equals the addr_i sampled at that edge and beat_o is 0 after that edge.
- R3: With mode_i = 0 (linear), each advance edge makes addr_o[1:0] the previous value plus one modulo 4, so the order starts from the loaded value.
- R4: With mode_i = 1 (interleaved), addr_o[1:0] equals the loaded low bits XOR beat_o, which gives the order L, L^1, L^2, L^3.
- R5: An advance edge (clk_en_ni low, adv_i high) never changes addr_o above bit 1.
- R6: Four advances after a load bring addr_o back to the loaded address and beat_o back to 0, and the sequence then repeats instead of stopping.
- R7: While clk_en_ni is high at a rising edge, addr_o and beat_o keep their values whatever adv_i and addr_i are.
- R8: Each advance edge increments beat_o by one modulo 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low; high freezes the block |
| adv_i | input | 1 | 1 advances the burst, 0 loads addr_i |
| mode_i | input | 1 | 0 selects linear order, 1 selects interleaved order |
| addr_i | input | ADDR_W (18) | Start address to load |
| addr_o | output | ADDR_W (18) | Current burst address |
| beat_o | output | BURST_W (2) | Beats since the last load |

## Verification
Load, advance and hold act on registers at the rising edge. Their effect on addr_o and beat_o therefore appears one cycle after the inputs are driven. The order selected by mode_i reaches addr_o combinationally from the registered state.

The driver sets inputs on the falling edge and queues the value expected after the next rising edge. The monitor takes that item from the queue 5 ns after the rising edge and compares it there. Mode is held from one falling edge to the next, so each sample sees a stable mode.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BURST_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               load_i,
  output logic [BURST_W-1:0] beat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_o <= '0;
    else if (en_i) begin
      if (load_i)    beat_o <= '0;
      else           beat_o <= beat_o + 1'b1;  // wraps at 2**BURST_W
    end
  end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_o <= '0;
    else if (load_i) base_o <= addr_i;
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  burst_order_e       order_i,
  input  logic [BURST_W-1:0] start_i,
  input  logic [BURST_W-1:0] beat_i,
  output logic [BURST_W-1:0] low_o
);
  logic [BURST_W-1:0] lin_low, ilv_low;

  assign lin_low = start_i + beat_i;  // modulo 2**BURST_W
  assign ilv_low = start_i ^ beat_i;

  always_comb begin
    unique case (order_i)
      ORD_INTERLEAVE: low_o = ilv_low;
      default:        low_o = lin_low;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int BURST_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clk_en_ni,
  input  logic               adv_i,
  input  logic               mode_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [BURST_W-1:0] beat_o
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic               step_en, do_load;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] low_d;
  burst_order_e       order;

  assign step_en = !clk_en_ni;
  assign do_load = step_en && !adv_i;
  assign order   = burst_order_e'(mode_i);

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (do_load),
    .addr_i (addr_i),
    .base_o (base_q)
  );

  burst_beat_ctr #(.BURST_W(BURST_W)) u_beat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (step_en),
    .load_i (!adv_i),
    .beat_o (beat_o)
  );

  burst_order_map #(.BURST_W(BURST_W)) u_map (
    .order_i (order),
    .start_i (base_q[BURST_W-1:0]),
    .beat_i  (beat_o),
    .low_o   (low_d)
  );

  generate
    if (HI_W > 0) begin : g_hi
      assign addr_o = {base_q[ADDR_W-1:BURST_W], low_d};
    end else begin : g_nohi
      assign addr_o = low_d;
    end
  endgenerate
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W  = 18,
  parameter int BURST_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clk_en_ni,
  input logic               adv_i,
  input logic               mode_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [ADDR_W-1:0]  addr_o,
  input logic [BURST_W-1:0] beat_o
);
  logic advance, loading;
  assign advance = !clk_en_ni && adv_i;
  assign loading = !clk_en_ni && !adv_i;

  // R1
  always_comb if (!rst_ni) reset_zero_chk: assert (addr_o == '0 && beat_o == '0);

  // R2
  load_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loading |=> (addr_o == $past(addr_i) && beat_o == '0));

  // R3
  linear_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance && !mode_i) |=> (mode_i ||
      addr_o[BURST_W-1:0] == BURST_W'($past(addr_o[BURST_W-1:0]) + 1'b1)));

  // R4
  ilv_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance && mode_i) |=> (!mode_i ||
      (addr_o[BURST_W-1:0] ^ beat_o) == $past(addr_o[BURST_W-1:0] ^ beat_o)));

  // R5
  upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance |=> $stable(addr_o[ADDR_W-1:BURST_W]));

  // R7
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_ni |=> ($stable(beat_o) && (mode_i != $past(mode_i) || $stable(addr_o))));

  // R8
  beat_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance |=> beat_o == BURST_W'($past(beat_o) + 1'b1));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clk_en_ni (clk_en_ni),
  .adv_i     (adv_i),
  .mode_i    (mode_i),
  .addr_i    (addr_i),
  .addr_o    (addr_o),
  .beat_o    (beat_o)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
  localparam int AW = 18;
  localparam int BW = 2;

  typedef struct {
    logic [AW-1:0] addr;
    logic [BW-1:0] beat;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_n = 1'b1;
  logic          adv = 1'b0;
  logic          mode = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [BW-1:0] beat_out;

  exp_t          q[$];
  int            n_chk = 0;
  int            n_fail = 0;
  logic [AW-1:0] m_base = '0;
  logic [BW-1:0] m_beat = '0;

  always #10 clk = ~clk;  // 50 MHz

  burst_addr_seq #(.ADDR_W(AW), .BURST_W(BW)) uut (
    .clk_i (clk), .rst_ni (rst_n), .clk_en_ni (en_n), .adv_i (adv),
    .mode_i (mode), .addr_i (addr_in), .addr_o (addr_out), .beat_o (beat_out)
  );

  function automatic logic [AW-1:0] model_addr(input logic m);
    logic [BW-1:0] lo;
    lo = m ? (m_base[BW-1:0] ^ m_beat) : BW'(m_base[BW-1:0] + m_beat);
    return {m_base[AW-1:BW], lo};
  endfunction

  task automatic step(input logic e_n, input logic a, input logic m,
                      input logic [AW-1:0] ad, input string tag);
    exp_t it;
    @(negedge clk);
    en_n = e_n; adv = a; mode = m; addr_in = ad;
    if (!e_n) begin
      if (!a) begin m_base = ad; m_beat = '0; end
      else m_beat = m_beat + 1'b1;
    end
    it.addr = model_addr(m);
    it.beat = m_beat;
    it.tag  = tag;
    q.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      exp_t it;
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        it = q.pop_front();
        n_chk++;
        if (addr_out !== it.addr || beat_out !== it.beat) begin
          n_fail++;
          $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                   it.tag, addr_out, beat_out, it.addr, it.beat);
        end
      end
    end
  end

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;  // R1 during reset
    if (addr_out !== '0 || beat_out !== '0) begin
      n_fail++;
      $display("FAIL R1: addr=%h beat=%0d expected addr=0 beat=0", addr_out, beat_out);
    end
    @(negedge clk); rst_n = 1'b1;
    step(1'b1, 1'b0, 1'b0, 18'h1_2345, "R1_after_release");

    // linear burst from low bits 01
    step(1'b0, 1'b0, 1'b0, 18'h2_A5F1, "R2_load_linear");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 18'h0_0000, "R3_R5_R8_linear");
    step(1'b0, 1'b1, 1'b0, 18'h3_FFFF, "R6_linear_wrap");
    step(1'b0, 1'b1, 1'b0, 18'h0_0000, "R6_repeat");

    // linear from 11 (wrap through 00)
    step(1'b0, 1'b0, 1'b0, 18'h0_0F03, "R2_load_top");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 18'h1_1111, "R3_from_3");

    // interleaved from low bits 10
    step(1'b0, 1'b0, 1'b1, 18'h1_C3A6, "R2_load_ilv");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 18'h0_0001, "R4_R5_ilv");
    step(1'b0, 1'b1, 1'b1, 18'h0_0002, "R6_ilv_wrap");

    // interleaved from 01 and 11
    step(1'b0, 1'b0, 1'b1, 18'h0_0001, "R2_load_ilv1");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, 18'h0_0000, "R4_from_1");
    step(1'b0, 1'b0, 1'b1, 18'h3_0007, "R2_load_ilv3");
    for (int i = 0; i < 2; i++) step(1'b0, 1'b1, 1'b1, 18'h0_0000, "R4_from_3");

    // hold: load attempt and advance attempt both ignored
    step(1'b1, 1'b0, 1'b1, 18'h0_BEEF, "R7_hold_load");
    step(1'b1, 1'b1, 1'b1, 18'h1_0000, "R7_hold_adv");
    step(1'b0, 1'b1, 1'b1, 18'h0_0000, "R8_after_hold");

    // back-to-back loads
    step(1'b0, 1'b0, 1'b0, 18'h3_FFFE, "R2_b2b_a");
    step(1'b0, 1'b0, 1'b0, 18'h0_0003, "R2_b2b_b");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule